// File: doc/BRIEF.md
# Element-Serial Vector Execution Unit

This block runs vector arithmetic one element at a time. It holds a small register file of eight vector registers, each with 64 entries of 64 bits. One instruction names an operation, two source registers or one source register and a scalar, a destination register and a length. The unit then walks an element index from zero up to the length minus one. Each element goes through one shared integer lane, and one result is written back per accepted output beat.

Registers are filled through a valid/ready preload stream. Every result also leaves the block on a valid/ready result stream that carries the element index and the value. The sequencer advances only on a result handshake. While `out_ready` is low, the current element is held: nothing is written and the index does not move. The preload stream is back-pressured (`pl_ready` low) for the whole time an instruction runs. A start pulse is honoured only while the unit is idle. A one-cycle `done` pulse closes each instruction.

Top module: `vec_serial_unit`

## Requirements
- R1: After reset, `busy`, `done` and `out_valid` are low and `pl_ready` is high.
- R2: A preload beat (`pl_valid` and `pl_ready` both high at a clock edge) writes `pl_data` into entry `pl_idx` of register `pl_reg`. `pl_ready` is low whenever `busy` is high, and a beat offered then changes nothing.
- R3: `start` is taken only when `busy` is low. A start pulse while busy is ignored: it produces no result beats and no register writes.
- R4: Operation codes on `op`: 0 gives a+b, 1 gives a−b, 2 gives the product a·b, 3 gives b−a. Here a is element i of `src_a` and b is the second operand.
- R5: With `scalar_mode` = 0, b is element i of `src_b`. With `scalar_mode` = 1, b is the latched `scalar` for every element.
- R6: Elements are produced in index order 0..L−1, one per result handshake. `out_idx` shows the index, and each beat writes its value into the same entry of `dst` at that edge. Entries at index L and above are left untouched.
- R7: While `out_valid` is high and `out_ready` low, the next cycle still shows `out_valid` with the same `out_idx` and `out_data`.
- R8: `dst` may equal a source register. Each element uses the source value from before the instruction.
- R9: The effective length L is `vlen`, with values above 64 clamped to 64. A `vlen` of 0 raises `done` in the cycle after the start edge, with no result beats and `busy` never high.
- R10: `done` is high for exactly one cycle, the cycle after the final result handshake. `busy` is low in that cycle.
- R11: Add and subtract wrap modulo 2^64. Multiply keeps the low 64 bits of the product.
- R12: A preload beat accepted at the same edge as `start` is visible to the instruction it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pl_valid | input | 1 | Preload beat offered |
| pl_ready | output | 1 | Preload beat can be taken (unit idle) |
| pl_reg | input | 3 | Preload target register |
| pl_idx | input | 6 | Preload target entry |
| pl_data | input | 64 | Preload value |
| start | input | 1 | Instruction start pulse |
| op | input | 2 | Operation code (see R4) |
| scalar_mode | input | 1 | 1 = second operand is `scalar` |
| src_a | input | 3 | First source register |
| src_b | input | 3 | Second source register |
| dst | input | 3 | Destination register |
| scalar | input | 64 | Scalar operand |
| vlen | input | 7 | Requested element count |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| out_valid | output | 1 | Result beat offered |
| out_ready | input | 1 | Consumer takes result beat |
| out_idx | output | 6 | Element index of the result beat |
| out_data | output | 64 | Result value |

## Verification
Two functions can meet in the same clock edge, and the bench provokes both. In the first case, a preload beat and an accepted start share one edge. The bench overwrites entry 0 of a source register in that cycle and expects the first result to use the new value. In the second case, a start and a preload beat are both offered while an instruction is running. The bench judges these from the result stream and the register contents: it expects no extra beats, an unchanged destination, and the first instruction's results intact even where they read the entry that the refused preload targeted. Throughout, a pseudo-random `out_ready` stalls the stream, so the hold rule and the one-beat-per-handshake stepping are exercised at every element position.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
  typedef enum logic [1:0] {
    VOP_ADD  = 2'd0,
    VOP_SUB  = 2'd1,
    VOP_MUL  = 2'd2,
    VOP_RSUB = 2'd3
  } vop_e;
endpackage

// File: rtl/vsu_regfile.sv
module vsu_regfile #(
  parameter int NREG  = 8,
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] wreg,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [RW-1:0] ra_reg,
  input  logic [RW-1:0] rb_reg,
  input  logic [IW-1:0] r_idx,
  output logic [W-1:0]  ra_data,
  output logic [W-1:0]  rb_data
);
  logic [W-1:0] mem [NREG][DEPTH];

  // reads are combinational, so an element is read before the edge that overwrites it
  always_ff @(posedge clk) begin
    if (we) mem[wreg][widx] <= wdata;
  end

  assign ra_data = mem[ra_reg][r_idx];
  assign rb_data = mem[rb_reg][r_idx];
endmodule

// File: rtl/vsu_lane.sv
module vsu_lane #(
  parameter int W = 64
) (
  input  vsu_pkg::vop_e op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [W-1:0]  y
);
  import vsu_pkg::*;
  always_comb begin
    unique case (op)
      VOP_ADD:  y = a + b;
      VOP_SUB:  y = a - b;
      VOP_MUL:  y = a * b;
      VOP_RSUB: y = b - a;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/vsu_seq.sv
module vsu_seq #(
  parameter int NREG  = 8,
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          scalar_mode,
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  input  logic [RW-1:0] dst,
  input  logic [W-1:0]  scalar,
  input  logic [LW-1:0] vlen,
  input  logic          out_ready,
  output logic          run,
  output logic          fire,
  output logic          done,
  output logic [IW-1:0] idx,
  output vsu_pkg::vop_e op_q,
  output logic          sm_q,
  output logic [RW-1:0] a_q,
  output logic [RW-1:0] b_q,
  output logic [RW-1:0] dst_q,
  output logic [W-1:0]  sc_q
);
  import vsu_pkg::*;

  logic [LW-1:0] len_q;
  logic [LW-1:0] eff_len;
  logic          take;
  logic          last;

  assign eff_len = (vlen > LW'(DEPTH)) ? LW'(DEPTH) : vlen;
  assign take    = start && !run;
  assign fire    = run && out_ready;
  assign last    = (LW'(idx) == (len_q - LW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      len_q <= '0;
      op_q  <= VOP_ADD;
      sm_q  <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
      dst_q <= '0;
      sc_q  <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        op_q  <= vop_e'(op);
        sm_q  <= scalar_mode;
        a_q   <= src_a;
        b_q   <= src_b;
        dst_q <= dst;
        sc_q  <= scalar;
        len_q <= eff_len;
        idx   <= '0;
        if (eff_len == '0) done <= 1'b1;
        else               run  <= 1'b1;
      end else if (fire) begin
        if (last) begin
          run  <= 1'b0;
          done <= 1'b1;
          idx  <= '0;
        end else begin
          idx <= idx + IW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/vec_serial_unit.sv
module vec_serial_unit #(
  parameter int NREG  = 8,
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int RW   = $clog2(NREG),
  localparam int IW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pl_valid,
  output logic          pl_ready,
  input  logic [RW-1:0] pl_reg,
  input  logic [IW-1:0] pl_idx,
  input  logic [W-1:0]  pl_data,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          scalar_mode,
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  input  logic [RW-1:0] dst,
  input  logic [W-1:0]  scalar,
  input  logic [LW-1:0] vlen,
  output logic          busy,
  output logic          done,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_idx,
  output logic [W-1:0]  out_data
);
  import vsu_pkg::*;

  logic          run, fire, sm_q;
  logic [IW-1:0] idx;
  vop_e          op_q;
  logic [RW-1:0] a_q, b_q, dst_q;
  logic [W-1:0]  sc_q, ra, rb, opnd_b, res;
  logic          pl_take, we;
  logic [RW-1:0] wreg;
  logic [IW-1:0] widx;
  logic [W-1:0]  wdata;

  vsu_seq #(.NREG(NREG), .DEPTH(DEPTH), .W(W)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .scalar_mode(scalar_mode),
    .src_a(src_a), .src_b(src_b), .dst(dst), .scalar(scalar), .vlen(vlen),
    .out_ready(out_ready), .run(run), .fire(fire), .done(done), .idx(idx),
    .op_q(op_q), .sm_q(sm_q), .a_q(a_q), .b_q(b_q), .dst_q(dst_q), .sc_q(sc_q)
  );

  assign pl_ready = !run;
  assign pl_take  = pl_valid && pl_ready;
  assign we       = fire || pl_take;
  assign wreg     = run ? dst_q : pl_reg;
  assign widx     = run ? idx   : pl_idx;
  assign wdata    = run ? res   : pl_data;

  vsu_regfile #(.NREG(NREG), .DEPTH(DEPTH), .W(W)) rf_i (
    .clk(clk), .we(we), .wreg(wreg), .widx(widx), .wdata(wdata),
    .ra_reg(a_q), .rb_reg(b_q), .r_idx(idx), .ra_data(ra), .rb_data(rb)
  );

  assign opnd_b = sm_q ? sc_q : rb;

  vsu_lane #(.W(W)) lane_i (.op(op_q), .a(ra), .b(opnd_b), .y(res));

  assign busy      = run;
  assign out_valid = run;
  assign out_idx   = idx;
  assign out_data  = res;
endmodule

// File: rtl/vsu_checker.sv
module vsu_checker #(
  parameter int IW = 6,
  parameter int W  = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          pl_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_idx,
  input logic [W-1:0]  out_data
);
  a_r2_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pl_ready);

  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_data)));

  a_r6_first_index: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_idx == '0));

  a_r6_step_index: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || out_idx == IW'($past(out_idx) + 1'b1)));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> done);
endmodule

bind vec_serial_unit vsu_checker #(.IW(IW), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pl_ready(pl_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx), .out_data(out_data)
);

// File: tb/vec_serial_unit_tb_top.sv
module vec_serial_unit_tb_top;
  localparam int NREG = 8, DEPTH = 64, W = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic pl_valid = 0, start = 0, scalar_mode = 0;
  logic [2:0] pl_reg = 0, src_a = 0, src_b = 0, dst = 0;
  logic [5:0] pl_idx = 0;
  logic [63:0] pl_data = 0, scalar = 0;
  logic [1:0] op = 0;
  logic [6:0] vlen = 0;
  logic pl_ready, busy, done, out_valid, out_ready;
  logic [5:0] out_idx;
  logic [63:0] out_data;

  vec_serial_unit dut_i (
    .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_reg(pl_reg),
    .pl_idx(pl_idx), .pl_data(pl_data), .start(start), .op(op), .scalar_mode(scalar_mode),
    .src_a(src_a), .src_b(src_b), .dst(dst), .scalar(scalar), .vlen(vlen), .busy(busy),
    .done(done), .out_valid(out_valid), .out_ready(out_ready), .out_idx(out_idx),
    .out_data(out_data)
  );

  logic [63:0] model [NREG][DEPTH];
  logic [63:0] exp_q[$];
  int          exp_idx_q[$];
  int n_chk = 0, n_fail = 0;
  string tag = "";
  bit finished = 0;

  logic [15:0] lfsr = 16'hACE1;
  always @(posedge clk) begin
    #1 lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end
  assign out_ready = lfsr[0] | lfsr[2];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // monitor: pops expected items as result beats are accepted
  bit pend_done = 0, hold_v = 0;
  logic [5:0] hold_idx;
  logic [63:0] hold_data;
  always @(negedge clk) begin
    logic [63:0] e;
    int i;
    if (rst_n) begin
      if (pend_done) begin
        check(done === 1'b1, "R10 done after last beat", 64'(done), 64'd1);
        pend_done = 0;
      end
      if (hold_v) begin
        check(out_valid && out_idx == hold_idx && out_data == hold_data,
              "R7 stalled beat held", out_data, hold_data);
        hold_v = 0;
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R3 R6 unexpected beat", out_data, 64'd0);
        else begin
          e = exp_q.pop_front();
          i = exp_idx_q.pop_front();
          check(out_idx == 6'(i), {tag, " index"}, 64'(out_idx), 64'(i));
          check(out_data == e, {tag, " value"}, out_data, e);
          if (exp_q.size() == 0) pend_done = 1;
        end
      end else if (out_valid) begin
        hold_v = 1; hold_idx = out_idx; hold_data = out_data;
      end
    end
  end

  task automatic preload_reg(input int r, input logic [63:0] base, input logic [63:0] step);
    for (int k = 0; k < DEPTH; k++) begin
      @(posedge clk); #1;
      pl_valid = 1; pl_reg = 3'(r); pl_idx = 6'(k);
      pl_data = base ^ (step * 64'(k + 1));
      model[r][k] = pl_data;
    end
    @(posedge clk); #1 pl_valid = 0;
  endtask

  task automatic run_instr(input logic [1:0] op_i, input bit sm, input int a, input int b,
                           input int d, input logic [63:0] sc, input int vl, input string t,
                           input bit poke = 0, input bit with_pl = 0, input int pr = 0,
                           input logic [63:0] pd = 0);
    int n;
    logic [63:0] x, y, r;
    n = (vl > DEPTH) ? DEPTH : vl;
    if (with_pl) model[pr][0] = pd;
    for (int k = 0; k < n; k++) begin
      x = model[a][k];
      y = sm ? sc : model[b][k];
      case (op_i)
        2'd0: r = x + y;
        2'd1: r = x - y;
        2'd2: r = x * y;
        default: r = y - x;
      endcase
      model[d][k] = r;
      exp_q.push_back(r);
      exp_idx_q.push_back(k);
    end
    tag = t;
    @(posedge clk); #1;
    start = 1; op = op_i; scalar_mode = sm; src_a = 3'(a); src_b = 3'(b);
    dst = 3'(d); scalar = sc; vlen = 7'(vl);
    if (with_pl) begin pl_valid = 1; pl_reg = 3'(pr); pl_idx = 0; pl_data = pd; end
    @(posedge clk); #1;
    start = 0; pl_valid = 0;
    if (n == 0) begin
      @(negedge clk);
      check(done && !busy && !out_valid, "R9 zero length completes at once", 64'(done), 64'd1);
      @(negedge clk);
      check(!done && !busy, "R10 single-cycle done", 64'(done), 64'd0);
    end else begin
      if (poke) begin
        repeat (3) @(posedge clk);
        #1;
        check(busy && !pl_ready, "R2 preload refused while busy", 64'(pl_ready), 64'd0);
        start = 1; op = 2'd2; dst = 3'd7; vlen = 7'd5; scalar_mode = 1; scalar = 64'd9;
        pl_valid = 1; pl_reg = 3'(a); pl_idx = 6'd63; pl_data = 64'hBAD0_BAD0_BAD0_BAD0;
        @(posedge clk); #1;
        start = 0; pl_valid = 0;
      end
      while (!done) @(negedge clk);
      check(!busy, "R10 busy low with done", 64'(busy), 64'd0);
      check(exp_q.size() == 0, "R6 every element delivered", 64'(exp_q.size()), 64'd0);
      @(negedge clk);
      check(!done, "R10 single-cycle done", 64'(done), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !out_valid && pl_ready, "R1 reset state",
          {60'd0, busy, done, out_valid, pl_ready}, 64'd1);

    preload_reg(0, 64'h0123_4567_89AB_CDEF, 64'h0000_0001_0000_0003);
    preload_reg(1, 64'hFFFF_FFFF_FFFF_FF00, 64'd3);
    preload_reg(2, 64'hDEAD_0000_0000_0007, 64'h0000_0100_0000_0011);
    preload_reg(4, 64'h5555_0000_0000_0000, 64'd1);

    run_instr(2'd0, 0, 0, 1, 3, 0, 64, "R4 R11 add vector-vector wrap");
    run_instr(2'd1, 1, 4, 0, 4, 64'h0000_0000_0000_1000, 17, "R5 R8 subtract scalar in place");
    run_instr(2'd0, 1, 4, 0, 5, 64'd0, 64, "R6 tail beyond length untouched");
    run_instr(2'd2, 0, 0, 1, 6, 0, 64, "R11 multiply low half");
    run_instr(2'd3, 1, 2, 0, 7, 64'd5, 64, "R4 reverse subtract");
    run_instr(2'd0, 0, 3, 3, 3, 0, 64, "R8 all operands same register");
    run_instr(2'd0, 0, 0, 1, 2, 0, 0, "R9 zero length");
    run_instr(2'd2, 1, 2, 0, 2, 64'hFFFF_FFFF_0000_0003, 100, "R9 clamp to full length");
    run_instr(2'd1, 0, 5, 0, 5, 0, 64, "R3 start while busy ignored", 1);
    run_instr(2'd0, 1, 7, 0, 6, 64'd0, 8, "R3 ignored start left register intact");
    run_instr(2'd0, 0, 0, 1, 1, 0, 1, "R6 single element");
    run_instr(2'd1, 0, 0, 2, 1, 0, 8, "R12 preload with start", 0, 1, 0, 64'h1234_5678_9ABC_DEF0);

    repeat (3) @(negedge clk);
    check(!out_valid && !busy, "R3 no stray activity", 64'(out_valid), 64'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule